// File: doc/BRIEF.md
# Instruction Predicate Evaluation Unit

This block decides, for each instruction, whether its results commit. It reads the condition field from the instruction word, the bit that marks the short-immediate operand form, the stored carry, sign and zero flags, and four external binary inputs. It also reads two qualifiers from the decoder: whether the opcode belongs to the predicated class, and whether the instruction uses the 8-bit immediate form, which has no condition field. It drives one commit enable. When the enable is low, the surrounding core drops register writeback, flag updates and any PC load caused by the instruction, and PC still steps to the next instruction.

The condition field is four bits wide. The top bit sets the polarity: 1 means "when true" and 0 means "when false". The two middle bits select the source: 00 selects the constant, which gives always or never, 01 selects carry, 10 selects sign and 11 selects zero. In register-operand form the bottom bit, when set, changes the source to an external input, and the two middle bits then give its index. In short-immediate form the bottom bit is forced to zero, so the same field acts as a 3-bit code. The external inputs are asynchronous. They pass through a two-flop synchronizer before evaluation.

The internal structure has one enumerated type, the condition source, with the values SRC_ALWAYS, SRC_CARRY, SRC_SIGN, SRC_ZERO and SRC_EXT. The decoder assigns one source to each instruction. No sequencing state exists beyond the synchronizer stages.

Top module: `pred_unit`

## Requirements
- R1: In short-immediate mode (imm4_mode_i=1), field bits [3:1] decode as follows:
  - 000: never
  - 001: carry=0
  - 010: sign=0
  - 011: zero=0
  - 100: always
  - 101: carry=1
  - 110: sign=1
  - 111: zero=1
- R2: Field bit 3 is the polarity bit. For the same source, the two values of this bit give opposite commit results. Field 0000 never commits and field 1000 always commits, in either operand mode.
- R3: In register mode (imm4_mode_i=0), field bit 0 selects the source type:
  - Bit 0 = 0: bits [2:1] select the flag exactly as in R1.
  - Bit 0 = 1: bits [2:1] give the index n of external input Bn. The codes 0001, 0011, 0101 and 0111 mean Bn=0. Codes 1001, 1011, 1101 and 1111 mean Bn=1.
- R4: In short-immediate mode, field bit 0 has no effect. Field 1001 commits even when all external inputs are 0.
- R5: When predicable_i=0, commit_o is 1 whatever the field, the flags and the external inputs hold.
- R6: When imm8_form_i=1, commit_o is 1 whatever the field holds.
- R7: A change on ext_async_i reaches the evaluation after exactly two rising clock edges. After the first edge the old value is still used.
- R8: While rst_n is low, the synchronized external inputs read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_field_i | input | 4 | Condition field of the instruction word |
| imm4_mode_i | input | 1 | 1 = short-immediate operand form, 0 = register operand form |
| imm8_form_i | input | 1 | 1 = 8-bit immediate form, which has no condition field |
| predicable_i | input | 1 | 1 = opcode belongs to the predicated class |
| carry_i | input | 1 | Stored carry flag |
| sign_i | input | 1 | Stored sign flag (MSB of the last result) |
| zero_i | input | 1 | Stored zero flag |
| ext_async_i | input | 4 | Asynchronous external condition inputs B0..B3 |
| commit_o | output | 1 | 1 = the instruction commits its results |

## Verification
If the source is selected wrongly or the polarity is inverted, the error shows on commit_o in the same cycle, because the path from field and flags to the enable has no registers. A synchronizer stage that is dropped or added moves an external-input change one edge earlier or later, and the bench detects it at the first and second edge after the change. A mask leak in short-immediate mode shows as a missing commit on field 1001 when the external inputs are low.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int COND_W    = 4;
    localparam int NUM_EXT   = 4;
    localparam int EXT_IDX_W = $clog2(NUM_EXT);

    typedef enum logic [2:0] {
        SRC_ALWAYS = 3'd0,
        SRC_CARRY  = 3'd1,
        SRC_SIGN   = 3'd2,
        SRC_ZERO   = 3'd3,
        SRC_EXT    = 3'd4
    } cond_src_e;

    typedef struct packed {
        cond_src_e              src;
        logic [EXT_IDX_W-1:0]   ext_idx;
        logic                   polarity;
    } cond_dec_t;

endpackage

// File: rtl/pred_sync.sv
module pred_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

    // cycles since reset, saturating, for latency assertion
    logic [1:0] since_rst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst_q <= 2'd0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_SYNC_RESET_ZERO: assert (sync_o == '0); // R8
        end
    end

    generate
        if (STAGES == 2) begin : g_lat2
            AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst_q >= 2'd2) |-> (sync_o == $past(async_i, 2))); // R7
        end
    endgenerate

endmodule

// File: rtl/pred_decode.sv
module pred_decode
    import pred_pkg::*;
(
    input  logic [COND_W-1:0] cond_field_i,
    input  logic              imm4_mode_i,
    output cond_dec_t         dec_o
);

    logic ext_sel;

    // LSB of the field only reaches the external inputs in register form
    assign ext_sel = cond_field_i[0] & ~imm4_mode_i;

    always_comb begin
        dec_o.polarity = cond_field_i[COND_W-1];
        dec_o.ext_idx  = cond_field_i[2:1];
        if (ext_sel) begin
            dec_o.src = SRC_EXT;
        end else begin
            unique case (cond_field_i[2:1])
                2'b00:   dec_o.src = SRC_ALWAYS;
                2'b01:   dec_o.src = SRC_CARRY;
                2'b10:   dec_o.src = SRC_SIGN;
                2'b11:   dec_o.src = SRC_ZERO;
                default: dec_o.src = SRC_ALWAYS;
            endcase
        end
    end

    always_comb begin
        if (imm4_mode_i) begin
            AST_DEC_NO_EXT_IN_IMM4: assert (dec_o.src != SRC_EXT); // R4
        end
    end

endmodule

// File: rtl/pred_eval.sv
module pred_eval
    import pred_pkg::*;
(
    input  cond_dec_t           dec_i,
    input  logic                carry_i,
    input  logic                sign_i,
    input  logic                zero_i,
    input  logic [NUM_EXT-1:0]  ext_sync_i,
    output logic                cond_met_o
);

    logic raw;

    always_comb begin
        unique case (dec_i.src)
            SRC_ALWAYS: raw = 1'b1;
            SRC_CARRY:  raw = carry_i;
            SRC_SIGN:   raw = sign_i;
            SRC_ZERO:   raw = zero_i;
            SRC_EXT:    raw = ext_sync_i[dec_i.ext_idx];
            default:    raw = 1'b0;
        endcase
    end

    assign cond_met_o = dec_i.polarity ? raw : ~raw;

endmodule

// File: rtl/pred_unit.sv
module pred_unit
    import pred_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COND_W-1:0]  cond_field_i,
    input  logic               imm4_mode_i,
    input  logic               imm8_form_i,
    input  logic               predicable_i,
    input  logic               carry_i,
    input  logic               sign_i,
    input  logic               zero_i,
    input  logic [NUM_EXT-1:0] ext_async_i,
    output logic               commit_o
);

    logic [NUM_EXT-1:0] ext_sync;
    cond_dec_t          dec;
    logic               cond_met;
    logic               unconditional;

    pred_sync #(
        .WIDTH  (NUM_EXT),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_async_i),
        .sync_o  (ext_sync)
    );

    pred_decode i_decode (
        .cond_field_i (cond_field_i),
        .imm4_mode_i  (imm4_mode_i),
        .dec_o        (dec)
    );

    pred_eval i_eval (
        .dec_i      (dec),
        .carry_i    (carry_i),
        .sign_i     (sign_i),
        .zero_i     (zero_i),
        .ext_sync_i (ext_sync),
        .cond_met_o (cond_met)
    );

    assign unconditional = ~predicable_i | imm8_form_i;
    assign commit_o      = unconditional | cond_met;

    AST_NONPRED_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        !predicable_i |-> commit_o); // R5
    AST_IMM8_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        imm8_form_i |-> commit_o); // R6
    AST_NEVER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (predicable_i && !imm8_form_i && cond_field_i == 4'b0000) |-> !commit_o); // R2
    AST_ALWAYS_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_field_i == 4'b1000) |-> commit_o); // R2
    AST_IMM4_MASKS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (imm4_mode_i && cond_field_i == 4'b1001) |-> commit_o); // R4

endmodule

// File: tb/test_pred_unit.sv
module test_pred_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond_field_i = 4'b0001;
    logic       imm4_mode_i = 1'b0;
    logic       imm8_form_i = 1'b0;
    logic       predicable_i = 1'b1;
    logic       carry_i = 1'b0;
    logic       sign_i = 1'b0;
    logic       zero_i = 1'b0;
    logic [3:0] ext_async_i = 4'hF;
    logic       commit_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pred_unit i_pred_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .cond_field_i (cond_field_i),
        .imm4_mode_i  (imm4_mode_i),
        .imm8_form_i  (imm8_form_i),
        .predicable_i (predicable_i),
        .carry_i      (carry_i),
        .sign_i       (sign_i),
        .zero_i       (zero_i),
        .ext_async_i  (ext_async_i),
        .commit_o     (commit_o)
    );

    function automatic logic model(input logic [3:0] f, input logic imm4,
                                   input logic imm8, input logic pred,
                                   input logic c, input logic s, input logic z,
                                   input logic [3:0] b);
        if (!pred || imm8) return 1'b1;
        if (imm4) begin
            case (f[3:1])
                3'b000: return 1'b0;
                3'b001: return !c;
                3'b010: return !s;
                3'b011: return !z;
                3'b100: return 1'b1;
                3'b101: return c;
                3'b110: return s;
                default: return z;
            endcase
        end
        case (f)
            4'h0: return 1'b0;
            4'h1: return !b[0];
            4'h2: return !c;
            4'h3: return !b[1];
            4'h4: return !s;
            4'h5: return !b[2];
            4'h6: return !z;
            4'h7: return !b[3];
            4'h8: return 1'b1;
            4'h9: return b[0];
            4'hA: return c;
            4'hB: return b[1];
            4'hC: return s;
            4'hD: return b[2];
            4'hE: return z;
            default: return b[3];
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: commit_o=%0b expected %0b (field=%b imm4=%0b imm8=%0b pred=%0b)",
                     req, got, exp, cond_field_i, imm4_mode_i, imm8_form_i, predicable_i);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0] bval;
        string tag;
        void'($urandom(32'd20240517));

        // R8: in reset the synced inputs read 0, so B0=0 holds despite ext=F
        @(posedge clk); @(posedge clk); #2;
        check(commit_o, 1'b1, "R8");
        cond_field_i = 4'b1111; #1;
        check(commit_o, 1'b0, "R8");

        @(negedge clk); rst_n = 1'b1; ext_async_i = 4'h0;
        repeat (3) @(posedge clk);
        #2;

        // R7: latency of two edges
        cond_field_i = 4'b1001; imm4_mode_i = 1'b0; #1;
        check(commit_o, 1'b0, "R7");
        @(negedge clk); ext_async_i = 4'h1;
        @(posedge clk); #2;
        check(commit_o, 1'b0, "R7");
        @(posedge clk); #2;
        check(commit_o, 1'b1, "R7");

        // R4: imm4 with field 1001 and all ext low commits
        @(negedge clk); ext_async_i = 4'h0;
        repeat (3) @(posedge clk); #2;
        imm4_mode_i = 1'b1; cond_field_i = 4'b1001; #1;
        check(commit_o, 1'b1, "R4");
        imm4_mode_i = 1'b0; #1;
        check(commit_o, 1'b0, "R3");

        // R1: all eight short codes with mixed flags
        for (int k = 0; k < 8; k++) begin
            for (int fl = 0; fl < 8; fl++) begin
                imm4_mode_i = 1'b1;
                cond_field_i = {k[2:0], fl[0]};
                {carry_i, sign_i, zero_i} = fl[2:0];
                #1;
                check(commit_o, model(cond_field_i, 1'b1, 1'b0, 1'b1,
                                      carry_i, sign_i, zero_i, 4'h0), "R1");
            end
        end

        // R2: polarity pairs in register mode
        imm4_mode_i = 1'b0; carry_i = 1'b1; sign_i = 1'b0; zero_i = 1'b1;
        cond_field_i = 4'b0010; #1; check(commit_o, 1'b0, "R2");
        cond_field_i = 4'b1010; #1; check(commit_o, 1'b1, "R2");
        cond_field_i = 4'b0000; #1; check(commit_o, 1'b0, "R2");
        cond_field_i = 4'b1000; #1; check(commit_o, 1'b1, "R2");

        // R5 and R6 directed
        predicable_i = 1'b0; cond_field_i = 4'b0000; #1; check(commit_o, 1'b1, "R5");
        predicable_i = 1'b1; imm8_form_i = 1'b1; #1; check(commit_o, 1'b1, "R6");
        imm8_form_i = 1'b0;

        // random mix, ext held stable across its synchronizer
        for (int it = 0; it < 30; it++) begin
            @(negedge clk);
            bval = 4'($urandom);
            ext_async_i = bval;
            @(posedge clk); @(posedge clk); #2;
            for (int j = 0; j < 8; j++) begin
                cond_field_i = 4'($urandom);
                imm4_mode_i  = 1'($urandom);
                imm8_form_i  = (($urandom % 8) == 0);
                predicable_i = (($urandom % 6) != 0);
                carry_i = 1'($urandom);
                sign_i  = 1'($urandom);
                zero_i  = 1'($urandom);
                #1;
                if (!predicable_i)     tag = "R5";
                else if (imm8_form_i)  tag = "R6";
                else if (imm4_mode_i)  tag = "R1";
                else                   tag = "R3";
                check(commit_o, model(cond_field_i, imm4_mode_i, imm8_form_i,
                                      predicable_i, carry_i, sign_i, zero_i, bval), tag);
            end
        end

        finish_run();
    end

endmodule